// File: doc/BRIEF.md
# Audio Sample FIFO with Level Checks

This block is a synchronous sample buffer that sits between a memory-side producer and an audio serial port. In the transmit build, the DMA side pushes samples and the serial port pops them. In the receive build, the serial port pushes and the DMA side pops. Software controls the buffer through five small registers:

- an operation register, to start, stop or clear the buffer;
- a level-check register, holding three fill thresholds;
- a read-only status register;
- a sticky interrupt-flag register, cleared by writing 1;
- an interrupt mask register.

The block raises a DMA request with hysteresis between the low and high thresholds, and drives one combined interrupt line.

A two-state controller governs the buffer. The states are IDLE (stopped) and RUN. Three transitions move between them:

- START: an operation write with the start bit set and the reset bit clear takes IDLE to RUN.
- STOP: an operation write with the start bit clear takes RUN to IDLE and keeps the contents.
- RESET: an operation write with the reset bit set empties the buffer and returns to IDLE from either state.

The intended order for software follows from this. Clear and start the buffer before the serial port is enabled. Disable the port before stopping the buffer.

The threshold field width `LVL_W` sets the depth, which is 2^LVL_W entries. The default of 6 is the transmit build. A receive build uses 4 with `IS_TX = 0`. That build flips the sense of the DMA request so that it asks for draining instead of filling.

Top module: `audfifo_lvlchk`

## Requirements
- R1: After reset the buffer is IDLE and empty. Status reads 4'b0010 (bit0 full, bit1 empty, bit2 overflow, bit3 underflow). The flag and mask registers (addresses 3 and 4) read 0, and `dma_req` and `irq` are low.
- R2: At address 0, writing bit0 = 1 with bit1 = 0 starts the buffer, and writing 0 stops it. A read of address 0 returns the running state in bit0, and bit1 always reads 0.
- R3: While IDLE, pushes and pops change neither the contents nor any flag, and `dma_req` stays low.
- R4: While RUN, samples leave in the order they were accepted. Up to 2^LVL_W samples are held, and status bit0 (full) and bit1 (empty) track the fill level.
- R5: A push while full is dropped and sets the overflow flag, which is flag bit0 and status bit2.
- R6: A pop while empty is dropped and sets the underflow flag, which is flag bit1 and status bit3.
- R7: Writing bit1 = 1 to address 0 empties the buffer and leaves it IDLE, whatever bit0 holds. The interrupt flags keep their values.
- R8: At address 1, the stop, low and high thresholds sit at bit offsets 0, 10 and 20, each LVL_W bits wide. Written bits outside those fields read back as 0.
- R9: In the transmit build, `dma_req` is high while RUN and the fill level is at or below the low threshold. It falls once the level reaches the high threshold, and between the two thresholds it holds its value. It changes on the same edge as the fill level.
- R10: Flag bit2 sets when a pop lowers the fill level to the stop threshold.
- R11: Writing 1 to a bit of address 3 clears that flag. Writing 0 leaves it unchanged.
- R12: `irq` is the OR of the flags whose bit is set in the mask at address 4. A mask of 0 silences every source.
- R13: In the receive build, `dma_req` rises once the fill level reaches the high threshold. It falls at or below the low threshold, and between the two thresholds it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 operation, 1 level-check, 2 status, 3 flags, 4 mask) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| push_valid | input | 1 | Push one sample this cycle |
| push_data | input | DW | Sample to push |
| pop_req | input | 1 | Pop the head sample this cycle |
| pop_data | output | DW | Head sample, valid while not empty |
| dma_req | output | 1 | Level-driven DMA request |
| irq | output | 1 | Combined masked interrupt |

## Verification
The assertions assume these input conditions:

- `rst_n` is held low for a few edges before any activity.
- `push_valid` and `pop_req` are plain one-cycle strobes.
- The low threshold is programmed below the high threshold, so the hysteresis band is non-empty.

The stimulus drives every input one time unit after a rising edge and holds each strobe for exactly one cycle. It programs thresholds with low < high in both builds, and it writes the operation register only between data strobes. Overflow and underflow are provoked on purpose, in both IDLE and RUN, to cover both the dropping and the ignoring paths.

// File: rtl/audfifo_pkg.sv
package audfifo_pkg;

    localparam int REG_AW = 3;
    localparam int REG_DW = 32;

    localparam logic [REG_AW-1:0] RA_OP   = 3'd0;
    localparam logic [REG_AW-1:0] RA_LVL  = 3'd1;
    localparam logic [REG_AW-1:0] RA_STAT = 3'd2;
    localparam logic [REG_AW-1:0] RA_INT  = 3'd3;
    localparam logic [REG_AW-1:0] RA_MASK = 3'd4;

    localparam int OP_START_BIT = 0;
    localparam int OP_RESET_BIT = 1;

    localparam int LVL_STOP_OFS = 0;
    localparam int LVL_LO_OFS   = 10;
    localparam int LVL_HI_OFS   = 20;

    localparam int NFLAG   = 3;
    localparam int FL_OVF  = 0;
    localparam int FL_UDF  = 1;
    localparam int FL_STOP = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } fifo_state_e;

endpackage

// File: rtl/audfifo_ctrl.sv
module audfifo_ctrl
    import audfifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_we,
    input  logic op_start,
    input  logic op_reset,
    input  logic push_valid,
    input  logic pop_req,
    input  logic full,
    input  logic empty,
    output logic running,
    output logic run_nxt,
    output logic clear,
    output logic push_en,
    output logic pop_en,
    output logic ovf_ev,
    output logic udf_ev
);

    fifo_state_e state_q, state_nxt;

    // Next-state logic: RESET, START and STOP transitions
    always_comb begin
        state_nxt = state_q;
        clear     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (op_we && op_reset) begin
                    clear     = 1'b1;
                    state_nxt = ST_IDLE;
                end else if (op_we && op_start) begin
                    state_nxt = ST_RUN;
                end
            end
            ST_RUN: begin
                if (op_we && op_reset) begin
                    clear     = 1'b1;
                    state_nxt = ST_IDLE;
                end else if (op_we && !op_start) begin
                    state_nxt = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // Outputs decoded from the current state
    always_comb begin
        running = (state_q == ST_RUN);
        run_nxt = (state_nxt == ST_RUN);
        push_en = running && push_valid && !full;
        pop_en  = running && pop_req && !empty;
        ovf_ev  = running && push_valid && full;
        udf_ev  = running && pop_req && empty;
    end

    // R2
    stop_leaves_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_we && !op_start) |=> !running);

endmodule

// File: rtl/audfifo_store.sv
module audfifo_store #(
    parameter int DW = 16,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push_en,
    input  logic          pop_en,
    input  logic [DW-1:0] push_data,
    output logic [DW-1:0] pop_data,
    output logic [AW:0]   count,
    output logic [AW:0]   count_nxt,
    output logic          full,
    output logic          empty
);

    localparam int DEPTH = 1 << AW;
    localparam int CW    = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;

    always_comb begin
        if (clear) begin
            count_nxt = '0;
        end else begin
            case ({push_en, pop_en})
                2'b10:   count_nxt = cnt_q + CW'(1);
                2'b01:   count_nxt = cnt_q - CW'(1);
                default: count_nxt = cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else if (clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_en) wr_ptr <= wr_ptr + AW'(1);
            if (pop_en)  rd_ptr <= rd_ptr + AW'(1);
            cnt_q <= count_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (push_en && !clear) mem[wr_ptr] <= push_data;
    end

    assign pop_data = mem[rd_ptr];
    assign count    = cnt_q;
    assign full     = (cnt_q == CW'(DEPTH));
    assign empty    = (cnt_q == '0);

    // R4
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && !pop_en) |-> !full);
    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> !empty);
    // R7
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> empty);

endmodule

// File: rtl/audfifo_dreq.sv
module audfifo_dreq #(
    parameter int AW    = 6,
    parameter bit IS_TX = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_nxt,
    input  logic [AW:0]   count_nxt,
    input  logic [AW-1:0] lvl_lo,
    input  logic [AW-1:0] lvl_hi,
    output logic          dma_req
);

    localparam int CW = AW + 1;

    logic [CW-1:0] lo_x, hi_x;
    logic          req_q, req_hys;

    assign lo_x = {1'b0, lvl_lo};
    assign hi_x = {1'b0, lvl_hi};

    generate
        if (IS_TX) begin : g_tx
            always_comb begin
                if (count_nxt <= lo_x)      req_hys = 1'b1;
                else if (count_nxt >= hi_x) req_hys = 1'b0;
                else                        req_hys = req_q;
            end
            // R9
            tx_low_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (run_nxt && count_nxt <= lo_x) |=> dma_req);
        end else begin : g_rx
            always_comb begin
                if (count_nxt >= hi_x)      req_hys = 1'b1;
                else if (count_nxt <= lo_x) req_hys = 1'b0;
                else                        req_hys = req_q;
            end
            // R13
            rx_high_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (run_nxt && count_nxt >= hi_x) |=> dma_req);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= run_nxt ? req_hys : 1'b0;
    end

    assign dma_req = req_q;

endmodule

// File: rtl/audfifo_regs.sv
module audfifo_regs
    import audfifo_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              running,
    input  logic              full,
    input  logic              empty,
    input  logic [LVL_W:0]    count,
    input  logic              push_en,
    input  logic              pop_en,
    input  logic              ovf_ev,
    input  logic              udf_ev,
    output logic              op_we,
    output logic              op_start,
    output logic              op_reset,
    output logic [LVL_W-1:0]  lvl_lo,
    output logic [LVL_W-1:0]  lvl_hi,
    output logic              irq
);

    localparam int CW = LVL_W + 1;

    logic [LVL_W-1:0] stop_q, lo_q, hi_q;
    logic [NFLAG-1:0] flags_q, mask_q, w1c, set_ev;
    logic             stop_ev;
    logic             wdata_unused;

    assign op_we    = reg_we && (reg_addr == RA_OP);
    assign op_start = reg_wdata[OP_START_BIT];
    assign op_reset = reg_wdata[OP_RESET_BIT];
    assign wdata_unused = ^reg_wdata;

    assign stop_ev = pop_en && !push_en && (count == (CW'(stop_q) + CW'(1)));
    assign w1c     = (reg_we && reg_addr == RA_INT) ? reg_wdata[NFLAG-1:0] : '0;

    always_comb begin
        set_ev          = '0;
        set_ev[FL_OVF]  = ovf_ev;
        set_ev[FL_UDF]  = udf_ev;
        set_ev[FL_STOP] = stop_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_q  <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            mask_q  <= '0;
            flags_q <= '0;
        end else begin
            if (reg_we && reg_addr == RA_LVL) begin
                stop_q <= reg_wdata[LVL_STOP_OFS +: LVL_W];
                lo_q   <= reg_wdata[LVL_LO_OFS +: LVL_W];
                hi_q   <= reg_wdata[LVL_HI_OFS +: LVL_W];
            end
            if (reg_we && reg_addr == RA_MASK) mask_q <= reg_wdata[NFLAG-1:0];
            flags_q <= set_ev | (flags_q & ~w1c);
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_OP:   reg_rdata[OP_START_BIT] = running;
            RA_LVL: begin
                reg_rdata[LVL_STOP_OFS +: LVL_W] = stop_q;
                reg_rdata[LVL_LO_OFS +: LVL_W]   = lo_q;
                reg_rdata[LVL_HI_OFS +: LVL_W]   = hi_q;
            end
            RA_STAT: reg_rdata[3:0] = {flags_q[FL_UDF], flags_q[FL_OVF], empty, full};
            RA_INT:  reg_rdata[NFLAG-1:0] = flags_q;
            RA_MASK: reg_rdata[NFLAG-1:0] = mask_q;
            default: reg_rdata = '0;
        endcase
    end

    assign lvl_lo = lo_q;
    assign lvl_hi = hi_q;
    assign irq    = |(flags_q & mask_q);

    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[FL_OVF] && !w1c[FL_OVF]) |=> flags_q[FL_OVF]);
    // R12
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);
    // R10
    stop_from_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[FL_STOP]) |-> $past(pop_en));

endmodule

// File: rtl/audfifo_lvlchk.sv
module audfifo_lvlchk
    import audfifo_pkg::*;
#(
    parameter int DW    = 16,
    parameter int LVL_W = 6,
    parameter bit IS_TX = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              push_valid,
    input  logic [DW-1:0]     push_data,
    input  logic              pop_req,
    output logic [DW-1:0]     pop_data,
    output logic              dma_req,
    output logic              irq
);

    logic             op_we, op_start, op_reset;
    logic             running, run_nxt, clear, push_en, pop_en, ovf_ev, udf_ev;
    logic             full, empty;
    logic [LVL_W:0]   count, count_nxt;
    logic [LVL_W-1:0] lvl_lo, lvl_hi;

    audfifo_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .op_we(op_we), .op_start(op_start),
        .op_reset(op_reset), .push_valid(push_valid), .pop_req(pop_req),
        .full(full), .empty(empty), .running(running), .run_nxt(run_nxt),
        .clear(clear), .push_en(push_en), .pop_en(pop_en),
        .ovf_ev(ovf_ev), .udf_ev(udf_ev)
    );

    audfifo_store #(.DW(DW), .AW(LVL_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(clear), .push_en(push_en),
        .pop_en(pop_en), .push_data(push_data), .pop_data(pop_data),
        .count(count), .count_nxt(count_nxt), .full(full), .empty(empty)
    );

    audfifo_dreq #(.AW(LVL_W), .IS_TX(IS_TX)) u_dreq (
        .clk(clk), .rst_n(rst_n), .run_nxt(run_nxt), .count_nxt(count_nxt),
        .lvl_lo(lvl_lo), .lvl_hi(lvl_hi), .dma_req(dma_req)
    );

    audfifo_regs #(.LVL_W(LVL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .running(running),
        .full(full), .empty(empty), .count(count), .push_en(push_en),
        .pop_en(pop_en), .ovf_ev(ovf_ev), .udf_ev(udf_ev), .op_we(op_we),
        .op_start(op_start), .op_reset(op_reset), .lvl_lo(lvl_lo),
        .lvl_hi(lvl_hi), .irq(irq)
    );

    // R3
    req_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> running);

endmodule

// File: tb/tb_audfifo_lvlchk.sv
module tb_audfifo_lvlchk;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        tgt = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        pv = 1'b0;
    logic [15:0] pdata = '0;
    logic        pr = 1'b0;
    logic        pop_exp = 1'b0;
    logic        done = 1'b0;

    wire [31:0] rd_tx, rd_rx;
    wire [15:0] pop_tx, pop_rx;
    wire        req_tx, req_rx, irq_tx, irq_rx;

    int checks = 0;
    int errors = 0;
    logic [15:0] sb_q[$];

    audfifo_lvlchk dut (
        .clk(clk), .rst_n(rst_n), .reg_we(we & ~tgt), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rd_tx), .push_valid(pv & ~tgt),
        .push_data(pdata), .pop_req(pr & ~tgt), .pop_data(pop_tx),
        .dma_req(req_tx), .irq(irq_tx)
    );

    audfifo_lvlchk #(.DW(16), .LVL_W(4), .IS_TX(1'b0)) dut_rx (
        .clk(clk), .rst_n(rst_n), .reg_we(we & tgt), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rd_rx), .push_valid(pv & tgt),
        .push_data(pdata), .pop_req(pr & tgt), .pop_data(pop_rx),
        .dma_req(req_rx), .irq(irq_rx)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        addr = a;
        #1;
        v = tgt ? int'(rd_rx) : int'(rd_tx);
    endtask

    task automatic rdchk(input logic [2:0] a, input int exp, input string tag);
        int v;
        rd(a, v);
        check(v == exp, tag, v, exp);
    endtask

    // driver: queues the expected sample when the push should be accepted
    task automatic push(input logic [15:0] d, input bit acc);
        @(posedge clk); #1;
        pv = 1'b1; pdata = d;
        if (acc && !tgt) sb_q.push_back(d);
        @(posedge clk); #1;
        pv = 1'b0;
    endtask

    task automatic pop(input bit exp_data);
        @(posedge clk); #1;
        pr = 1'b1; pop_exp = exp_data;
        @(posedge clk); #1;
        pr = 1'b0; pop_exp = 1'b0;
    endtask

    task automatic reqchk(input bit exp, input string tag);
        bit v;
        v = tgt ? req_rx : req_tx;
        check(v == exp, tag, int'(v), int'(exp));
    endtask

    // monitor: compares the head sample against the scoreboard (R4)
    always @(negedge clk) begin
        if (pr && pop_exp && !tgt) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R4 scoreboard empty", int'(pop_tx), 0);
            end else begin
                logic [15:0] e;
                e = sb_q.pop_front();
                check(pop_tx == e, "R4 order", int'(pop_tx), int'(e));
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rdchk(3'd2, 32'h2, "R1 status");
        rdchk(3'd3, 0, "R1 flags");
        rdchk(3'd4, 0, "R1 mask");
        check(irq_tx == 1'b0, "R1 irq", int'(irq_tx), 0);
        reqchk(1'b0, "R1 dma_req");

        // R3 stopped buffer ignores traffic
        push(16'h1111, 1'b0);
        push(16'h2222, 1'b0);
        pop(1'b0);
        rdchk(3'd2, 32'h2, "R3 status while idle");
        rdchk(3'd3, 0, "R3 flags while idle");
        reqchk(1'b0, "R3 dma_req while idle");

        // R8 thresholds: stop 2, low 4, high 10, junk above each field
        wr(3'd1, (32'd10 << 20) | (32'd4 << 10) | 32'd2 | (32'd1 << 6) | (32'd1 << 16) | (32'd1 << 26));
        rdchk(3'd1, (10 << 20) | (4 << 10) | 2, "R8 level readback");

        // R2 start
        wr(3'd0, 32'h2);
        wr(3'd0, 32'h1);
        rdchk(3'd0, 1, "R2 running readback");
        reqchk(1'b1, "R9 request at empty");

        // R9 hysteresis while filling
        for (int i = 1; i <= 9; i++) push(16'hA000 + 16'(i), 1'b1);
        reqchk(1'b1, "R9 hold at 9");
        push(16'hA00A, 1'b1);
        reqchk(1'b0, "R9 drop at high");
        for (int i = 0; i < 5; i++) pop(1'b1);
        reqchk(1'b0, "R9 hold at 5");
        pop(1'b1);
        reqchk(1'b1, "R9 rise at low");

        // R10 stop threshold
        pop(1'b1);
        rdchk(3'd3, 0, "R10 no flag at 3");
        pop(1'b1);
        rdchk(3'd3, 4, "R10 flag at 2");
        check(irq_tx == 1'b0, "R12 masked irq", int'(irq_tx), 0);

        // R12 / R11
        wr(3'd4, 32'h4);
        check(irq_tx == 1'b1, "R12 unmasked irq", int'(irq_tx), 1);
        wr(3'd3, 32'h0);
        rdchk(3'd3, 4, "R11 write zero keeps");
        wr(3'd3, 32'h4);
        rdchk(3'd3, 0, "R11 write one clears");
        check(irq_tx == 1'b0, "R11 irq after clear", int'(irq_tx), 0);

        // R6 underflow
        pop(1'b1);
        pop(1'b1);
        pop(1'b0);
        rdchk(3'd3, 2, "R6 underflow flag");
        rdchk(3'd2, 32'hA, "R6 status");
        check(irq_tx == 1'b0, "R12 udf masked", int'(irq_tx), 0);
        wr(3'd4, 32'h7);
        check(irq_tx == 1'b1, "R12 udf unmasked", int'(irq_tx), 1);

        // R4 / R5 capacity and overflow
        for (int i = 0; i < 64; i++) push(16'h0100 + 16'(i), 1'b1);
        rdchk(3'd2, 32'h9, "R4 full status");
        push(16'hDEAD, 1'b0);
        rdchk(3'd2, 32'hD, "R5 overflow status");
        rdchk(3'd3, 3, "R5 overflow flag");
        for (int i = 0; i < 64; i++) pop(1'b1);
        rdchk(3'd2, 32'hE, "R4 empty after drain");
        check(sb_q.size() == 0, "R4 scoreboard drained", sb_q.size(), 0);
        wr(3'd3, 32'h7);
        rdchk(3'd3, 0, "R11 clear all");

        // R2 stop, R3 ignore
        wr(3'd0, 32'h0);
        rdchk(3'd0, 0, "R2 stopped readback");
        push(16'hBEEF, 1'b0);
        pop(1'b0);
        rdchk(3'd2, 32'h2, "R3 status after stop");
        rdchk(3'd3, 0, "R3 no flags after stop");
        reqchk(1'b0, "R3 dma_req after stop");

        // R7 reset keeps flags
        wr(3'd0, 32'h1);
        pop(1'b0);
        for (int i = 0; i < 3; i++) push(16'h5000 + 16'(i), 1'b1);
        wr(3'd0, 32'h3);
        sb_q.delete();
        rdchk(3'd2, 32'hA, "R7 empty after clear");
        rdchk(3'd0, 0, "R7 idle after clear");
        rdchk(3'd3, 2, "R7 flags kept");
        reqchk(1'b0, "R7 dma_req after clear");

        // R13 receive build: high 6, low 2
        tgt = 1'b1;
        wr(3'd1, (32'd6 << 20) | (32'd2 << 10));
        wr(3'd0, 32'h1);
        reqchk(1'b0, "R13 idle low");
        for (int i = 0; i < 5; i++) push(16'h7000 + 16'(i), 1'b0);
        reqchk(1'b0, "R13 below high");
        push(16'h7005, 1'b0);
        reqchk(1'b1, "R13 rise at high");
        for (int i = 0; i < 3; i++) pop(1'b0);
        reqchk(1'b1, "R13 hold at 3");
        pop(1'b0);
        reqchk(1'b0, "R13 drop at low");
        tgt = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule